// File: doc/BRIEF.md
# Gated Dual Event Counter

This block counts pulses on two asynchronous event lines, each with its own counter. One shared gate decides whether either counter may advance. While the gate is high, every rising edge of an event line increments that line's counter. While the gate is low, both counters hold their values. A control bit chooses where the gate comes from: an external gate pin, or a periodic PWM level produced elsewhere on the chip. The PWM generator is not part of this block and arrives as an input.

The chosen gate level also serves as an interrupt source. A programmable edge detector watches it and can react to rising edges, falling edges or both. A detected edge sets a sticky request flag. The flag produces a CPU request only while the interrupt enable bit is set. Software programs the block through a small write port and can clear the flag and either counter.

The event inputs and the gate pin pass through a two-flop synchroniser before any logic uses them. The PWM level is already in the system clock domain and is registered once.

Top module: `gated_evcnt`

## Requirements
- R1: After reset, both counters, the request flag, the CPU request and all control bits (source select, edge select, enable) are 0.
- R2: While the selected gate is high, each rising edge on `ev_in[i]` adds exactly one to counter i and leaves the other counter alone.
- R3: While the selected gate is low, event edges do not change either counter.
- R4: Control register (address 0) bit 0 selects the gate. 0 uses `gate_pin` and 1 uses `pwm_in`. The unselected source has no effect on counting.
- R5: One gate state applies to both counters at the same time, and a low gate stops them together.
- R6: A counter at all ones (0xFF with the default width) goes to 0 on its next counted event.
- R7: A write to address 2 clears counter i to 0 when data bit i is 1. A counter whose bit is 0 keeps its value.
- R8: Control register bits 2:1 set the edge mode. 00 detects falling gate edges, 01 detects rising gate edges, and 10 or 11 detect both. A detected edge sets `irq_flag` to 1.
- R9: `irq_flag` stays set until address 1 is written with data bit 0 equal to 0. Writing that bit as 1 leaves the flag unchanged, and an edge in the same cycle as a clear wins.
- R10: `irq_req` is 1 exactly when the flag is set and control bit 3 (enable) is 1, one cycle after that state. A flag that is pending while the enable is 0 raises the request once the enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_in | input | NUM_CNT | Asynchronous event lines, one per counter |
| gate_pin | input | 1 | Asynchronous external gate level |
| pwm_in | input | 1 | Gate level from the internal PWM generator, in the system clock domain |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address: 0 control, 1 flag, 2 counter clear |
| wr_data | input | DATA_W | Register write data |
| cnt_out | output | NUM_CNT*CNT_W | Counter values packed together, with counter i at bits [i*CNT_W +: CNT_W] |
| irq_flag | output | 1 | Sticky interrupt request flag |
| irq_req | output | 1 | Interrupt request to the CPU (flag qualified by the enable) |

## Verification
Counting is tried with pulse trains on one line alone, on the other line alone and on both lines together. These patterns separate per-counter increments from crosstalk between the counters. The same trains are repeated with the gate low, with each gate source selected in turn, and with the unselected source held at the opposite level. This shows whether the gate really stops both counters and whether the select bit really switches the source. A long train on one counter crosses the all-ones boundary. The gate is then driven through rising and falling transitions under each of the four edge codes, which tells each mode apart from the others. Flag writes with bit 0 set and cleared, and enable changes made while the flag is pending, exercise the sticky flag and the qualified request.

// File: rtl/gevc_pkg.sv
package gevc_pkg;

  typedef enum logic [1:0] {
    ES_FALL     = 2'b00,
    ES_RISE     = 2'b01,
    ES_BOTH     = 2'b10,
    ES_BOTH_ALT = 2'b11
  } edge_mode_e;

  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_FLAG = 1;
  localparam int unsigned REG_CLR  = 2;

  localparam int CTRL_SRC_BIT = 0;
  localparam int CTRL_ES_LSB  = 1;
  localparam int CTRL_EN_BIT  = 3;

endpackage

// File: rtl/gevc_sync.sv
module gevc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= '0;
    else     chain_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= '0;
      else     chain_q[s] <= chain_q[s-1];
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gevc_edge.sv
module gevc_edge
  import gevc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  edge_mode_e mode,
  input  logic       lvl,
  output logic       hit
);

  logic prev_q;
  logic rise;
  logic fall;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  always_comb begin
    unique case (mode)
      ES_FALL: hit = fall;
      ES_RISE: hit = rise;
      default: hit = rise | fall;
    endcase
  end

endmodule

// File: rtl/gevc_counter.sv
module gevc_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_lvl,
  input  logic             gate,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  logic ev_prev_q;
  logic step;

  always_ff @(posedge clk) begin
    if (rst) ev_prev_q <= 1'b0;
    else     ev_prev_q <= ev_lvl;
  end

  assign step = ev_lvl & ~ev_prev_q & gate;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/gated_evcnt.sv
module gated_evcnt
  import gevc_pkg::*;
#(
  parameter int NUM_CNT     = 2,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CNT-1:0]       ev_in,
  input  logic                     gate_pin,
  input  logic                     pwm_in,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [NUM_CNT*CNT_W-1:0] cnt_out,
  output logic                     irq_flag,
  output logic                     irq_req
);

  localparam int SYNC_W = NUM_CNT + 1;

  logic [SYNC_W-1:0]  sync_q;
  logic [NUM_CNT-1:0] ev_sync;
  logic               gpin_sync;
  logic               pwm_q;

  logic               src_sel_q;
  edge_mode_e         edge_mode_q;
  logic               irq_en_q;

  logic               wr_ctrl;
  logic               flag_clr_wr;
  logic [NUM_CNT-1:0] clr_vec;
  logic               gate_sel;
  logic               edge_hit;
  logic               unused_wr_bits;

  gevc_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({gate_pin, ev_in}),
    .q   (sync_q)
  );

  assign ev_sync   = sync_q[NUM_CNT-1:0];
  assign gpin_sync = sync_q[NUM_CNT];

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= pwm_in;
  end

  assign wr_ctrl     = wr_en && (wr_addr == ADDR_W'(REG_CTRL));
  assign flag_clr_wr = wr_en && (wr_addr == ADDR_W'(REG_FLAG)) && !wr_data[0];
  assign clr_vec     = (wr_en && (wr_addr == ADDR_W'(REG_CLR))) ? wr_data[NUM_CNT-1:0] : '0;
  assign unused_wr_bits = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_sel_q   <= 1'b0;
      edge_mode_q <= ES_FALL;
      irq_en_q    <= 1'b0;
    end else if (wr_ctrl) begin
      src_sel_q   <= wr_data[CTRL_SRC_BIT];
      edge_mode_q <= edge_mode_e'(wr_data[CTRL_ES_LSB +: 2]);
      irq_en_q    <= wr_data[CTRL_EN_BIT];
    end
  end

  assign gate_sel = src_sel_q ? pwm_q : gpin_sync;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    gevc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .ev_lvl (ev_sync[i]),
      .gate   (gate_sel),
      .clr    (clr_vec[i]),
      .cnt    (cnt_out[i*CNT_W +: CNT_W])
    );
  end

  gevc_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .mode (edge_mode_q),
    .lvl  (gate_sel),
    .hit  (edge_hit)
  );

  always_ff @(posedge clk) begin
    if (rst)              irq_flag <= 1'b0;
    else if (edge_hit)    irq_flag <= 1'b1;
    else if (flag_clr_wr) irq_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_req <= 1'b0;
    else     irq_req <= irq_flag & irq_en_q;
  end

endmodule

// File: rtl/gevc_checker.sv
module gevc_checker #(
  parameter int NUM_CNT = 2,
  parameter int CNT_W   = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     gate_sel,
  input logic                     edge_hit,
  input logic                     flag_clr_wr,
  input logic                     irq_en,
  input logic [NUM_CNT-1:0]       clr_vec,
  input logic [NUM_CNT*CNT_W-1:0] cnt_out,
  input logic                     irq_flag,
  input logic                     irq_req
);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (cnt_out == '0 && !irq_flag && !irq_req));

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((cnt_out[i*CNT_W +: CNT_W] == $past(cnt_out[i*CNT_W +: CNT_W]))
            || (cnt_out[i*CNT_W +: CNT_W] == $past(cnt_out[i*CNT_W +: CNT_W]) + 1'b1)
            || (cnt_out[i*CNT_W +: CNT_W] == '0)));
  end

  // R3 and R5: a low gate freezes every counter together
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!gate_sel && clr_vec == '0) |=> $stable(cnt_out));

  p_flag_set_r8: assert property (@(posedge clk) disable iff (rst)
    edge_hit |=> irq_flag);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !flag_clr_wr) |=> irq_flag);

  p_req_on_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && irq_en) |=> irq_req);

  p_req_off_r10: assert property (@(posedge clk) disable iff (rst)
    !irq_flag |=> !irq_req);

endmodule

bind gated_evcnt gevc_checker #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .gate_sel    (gate_sel),
  .edge_hit    (edge_hit),
  .flag_clr_wr (flag_clr_wr),
  .irq_en      (irq_en_q),
  .clr_vec     (clr_vec),
  .cnt_out     (cnt_out),
  .irq_flag    (irq_flag),
  .irq_req     (irq_req)
);

// File: tb/gated_evcnt_tb_top.sv
module gated_evcnt_tb_top;

  localparam int NC = 2;
  localparam int CW = 8;
  localparam int AW = 2;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst;
  logic [NC-1:0] ev;
  logic          gpin;
  logic          pwm;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [NC*CW-1:0] cnt;
  logic          flag;
  logic          req;

  int checks = 0;
  int errors = 0;
  int exp_cnt [NC];
  logic b_src = 1'b0;
  bit done = 1'b0;

  gated_evcnt #(.NUM_CNT(NC), .CNT_W(CW), .SYNC_STAGES(2), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .ev_in    (ev),
    .gate_pin (gpin),
    .pwm_in   (pwm),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cnt_out  (cnt),
    .irq_flag (flag),
    .irq_req  (req)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic set_ctrl(logic src, logic [1:0] es, logic en);
    wreg(2'd0, {4'b0, en, es, src});
    b_src = src;
  endtask

  function automatic logic gate_on();
    return b_src ? pwm : gpin;
  endfunction

  task automatic pulse(logic [NC-1:0] mask);
    @(negedge clk);
    ev = mask;
    idle(3);
    ev = '0;
    idle(3);
    for (int i = 0; i < NC; i++)
      if (mask[i] && gate_on()) exp_cnt[i] = (exp_cnt[i] + 1) % (1 << CW);
  endtask

  task automatic check_cnts(string tag);
    for (int i = 0; i < NC; i++)
      chk(tag, 32'(cnt[i*CW +: CW]), 32'(exp_cnt[i]));
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ev = '0; gpin = 1'b0; pwm = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    for (int i = 0; i < NC; i++) exp_cnt[i] = 0;
    idle(5);
    rst = 1'b0;
    idle(2);
    check_cnts("R1 counters");
    chk("R1 flag", 32'(flag), 0);
    chk("R1 req", 32'(req), 0);

    // R1: control resets to pin source, falling-edge mode
    gpin = 1'b1; idle(5);
    chk("R1 default source and mode", 32'(flag), 0);
    gpin = 1'b0; idle(5);
    chk("R1 default falling mode", 32'(flag), 1);
    chk("R1 enable off", 32'(req), 0);
    wreg(2'd1, 8'h00); idle(2);

    // R2: counting with the pin gate high
    set_ctrl(1'b0, 2'b01, 1'b0);
    gpin = 1'b1; idle(5);
    for (int n = 0; n < 5; n++) begin pulse(2'b01); check_cnts("R2 line0"); end
    for (int n = 0; n < 3; n++) begin pulse(2'b10); check_cnts("R2 line1"); end
    for (int n = 0; n < 2; n++) begin pulse(2'b11); check_cnts("R2 both"); end

    // R3/R5: low gate stops both together
    gpin = 1'b0; idle(5);
    for (int n = 0; n < 4; n++) pulse(2'b11);
    check_cnts("R3 R5 hold both");
    pulse(2'b01);
    check_cnts("R3 hold line0");

    // R4: PWM source
    pwm = 1'b1; gpin = 1'b0;
    set_ctrl(1'b1, 2'b01, 1'b0); idle(5);
    for (int n = 0; n < 3; n++) pulse(2'b11);
    check_cnts("R4 pwm high counts");
    pwm = 1'b0; gpin = 1'b1; idle(5);
    for (int n = 0; n < 3; n++) pulse(2'b11);
    check_cnts("R4 pwm low holds, pin ignored");
    pwm = 1'b1; gpin = 1'b0;
    set_ctrl(1'b0, 2'b01, 1'b0); idle(5);
    for (int n = 0; n < 3; n++) pulse(2'b11);
    check_cnts("R4 pin low holds, pwm ignored");

    // R6: wrap on counter 0
    gpin = 1'b1; idle(5);
    while (exp_cnt[0] != (1 << CW) - 1) pulse(2'b01);
    check_cnts("R6 at all ones");
    pulse(2'b01);
    check_cnts("R6 wrapped to zero");
    for (int n = 0; n < 4; n++) pulse(2'b01);
    check_cnts("R6 after wrap");

    // R7: per-counter clear
    for (int n = 0; n < 3; n++) pulse(2'b11);
    wreg(2'd2, 8'h01); idle(1); exp_cnt[0] = 0;
    check_cnts("R7 clear counter0 only");
    pulse(2'b11);
    wreg(2'd2, 8'h02); idle(1); exp_cnt[1] = 0;
    check_cnts("R7 clear counter1 only");
    wreg(2'd2, 8'h00); idle(1);
    check_cnts("R7 zero mask");

    // R8: edge modes
    for (int m = 0; m < 4; m++) begin
      gpin = 1'b0; idle(5);
      set_ctrl(1'b0, 2'(m), 1'b0);
      wreg(2'd1, 8'h00); idle(2);
      chk("R8 flag cleared", 32'(flag), 0);
      gpin = 1'b1; idle(5);
      chk($sformatf("R8 mode %0d rising", m), 32'(flag), (m != 0) ? 1 : 0);
      wreg(2'd1, 8'h00); idle(2);
      gpin = 1'b0; idle(5);
      chk($sformatf("R8 mode %0d falling", m), 32'(flag), (m != 1) ? 1 : 0);
      chk("R10 enable off no req", 32'(req), 0);
    end

    // R9: sticky flag
    set_ctrl(1'b0, 2'b10, 1'b0);
    wreg(2'd1, 8'h00); idle(2);
    gpin = 1'b1; idle(5);
    chk("R9 flag set", 32'(flag), 1);
    wreg(2'd1, 8'h01); idle(2);
    chk("R9 write one keeps flag", 32'(flag), 1);
    idle(10);
    chk("R9 flag stays", 32'(flag), 1);
    wreg(2'd1, 8'h00); idle(2);
    chk("R9 write zero clears", 32'(flag), 0);

    // R10: pending flag and enable
    gpin = 1'b0; idle(5);
    chk("R10 pending flag", 32'(flag), 1);
    chk("R10 no req while disabled", 32'(req), 0);
    set_ctrl(1'b0, 2'b10, 1'b1); idle(2);
    chk("R10 req after enable", 32'(req), 1);
    wreg(2'd1, 8'h00); idle(2);
    chk("R10 req drops with flag", 32'(req), 0);
    gpin = 1'b1; idle(6);
    chk("R10 req on new edge", 32'(req), 1);
    set_ctrl(1'b0, 2'b10, 1'b0); idle(2);
    chk("R10 req drops with enable", 32'(req), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule